// File: doc/BRIEF.md
# Bit-Serial Four-Bit Adder

This block adds two four-bit unsigned operands using a single full-adder cell that is reused once per clock. A start strobe captures both operands into right-shifting registers and clears a one-bit carry register. On each of the next four clocks the adder takes the lowest bit of each operand register and the stored carry. It shifts the sum bit into the top of a result register and stores the new carry for the next bit.

After the fourth step a one-cycle done pulse marks the result as complete. The sum and the final carry then stay on the outputs until another start arrives. A start raised during a computation abandons the current addition and begins again with the new operands.

Top module: `serial_adder`

## Requirements
- R1: While rst_ni is low, and after it is released with no start, sum_o is 0, carry_o is 0 and done_o is 0.
- R2: The clock edge that samples start_i high captures a_i and b_i and clears the carry and the result register. After that edge, sum_o is 0, carry_o is 0 and done_o is 0.
- R3: done_o is high only in the cycle after the fourth clock edge following the edge that sampled start_i, and it stays high for exactly one cycle.
- R4: While done_o is high, the five-bit value {carry_o, sum_o} equals the sum of the operands captured at the start edge, with carry_o as bit 4.
- R5: After done_o, sum_o and carry_o keep their values until the next start edge.
- R6: A start edge during a computation abandons it. Only the newest operands produce a result, and done_o follows four edges after that newest start.
- R7: a_i and b_i are ignored on every edge where start_i is low. Changing them during a computation does not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture operands and begin an addition |
| a_i | input | 4 | First operand |
| b_i | input | 4 | Second operand |
| sum_o | output | 4 | Result register, low four bits of the sum |
| carry_o | output | 1 | Carry register; final carry-out once done_o has pulsed |
| done_o | output | 1 | One-cycle pulse when the result is complete |

## Verification
The assertions assume that start_i is a synchronous level, sampled once per edge. They also assume that the operand inputs matter only on the edge that samples start_i, so the checker keeps its own copy of the operands taken at that edge. The stimulus changes start_i, a_i and b_i only on falling clock edges. It deliberately drives the bit-inverted operands while an addition is running and sometimes issues a new start before done_o, so the capture-only and restart behaviour is exercised. Besides directed corner pairs, the bench runs all 256 operand combinations.

// File: rtl/serial_adder_pkg.sv
package serial_adder_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } sa_state_e;
endpackage

// File: rtl/sa_full_adder.sv
module sa_full_adder (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  assign s_o = a_i ^ b_i ^ c_i;
  assign c_o = (a_i & b_i) | (c_i & (a_i ^ b_i));
endmodule

// File: rtl/sa_shift_reg.sv
module sa_shift_reg #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         shift_i,
  input  logic         ser_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  // load wins over shift; shift moves right, ser_i enters at the MSB
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q <= '0;
    end else if (load_i) begin
      q_q <= load_val_i;
    end else if (shift_i) begin
      q_q <= {ser_i, q_q[W-1:1]};
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/sa_step_ctrl.sv
module sa_step_ctrl
  import serial_adder_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic step_o,
  output logic done_o
);
  localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  sa_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        state_q <= ST_RUN;
        cnt_q   <= '0;
      end else if (state_q == ST_RUN) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
      end
    end
  end

  assign step_o = (state_q == ST_RUN);
  assign done_o = done_q;
endmodule

// File: rtl/serial_adder.sv
module serial_adder #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o,
  output logic         done_o
);
  logic         step;
  logic [W-1:0] opa_q, opb_q, res_q;
  logic         carry_q;
  logic         fa_s, fa_c;

  sa_step_ctrl #(.W(W)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .step_o (step),
    .done_o (done_o)
  );

  sa_shift_reg #(.W(W)) u_opa (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (start_i),
    .load_val_i(a_i),
    .shift_i   (step),
    .ser_i     (1'b0),
    .q_o       (opa_q)
  );

  sa_shift_reg #(.W(W)) u_opb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (start_i),
    .load_val_i(b_i),
    .shift_i   (step),
    .ser_i     (1'b0),
    .q_o       (opb_q)
  );

  sa_full_adder u_fa (
    .a_i(opa_q[0]),
    .b_i(opb_q[0]),
    .c_i(carry_q),
    .s_o(fa_s),
    .c_o(fa_c)
  );

  // sum bits enter at the top so the LSB lands in bit 0 after W shifts
  sa_shift_reg #(.W(W)) u_res (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (start_i),
    .load_val_i('0),
    .shift_i   (step),
    .ser_i     (fa_s),
    .q_o       (res_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      carry_q <= 1'b0;
    end else if (start_i) begin
      carry_q <= 1'b0;
    end else if (step) begin
      carry_q <= fa_c;
    end
  end

  assign sum_o   = res_q;
  assign carry_o = carry_q;
endmodule

// File: rtl/serial_adder_chk.sv
module serial_adder_chk #(
  parameter int unsigned W = 4
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [W-1:0] sum_o,
  input logic         carry_o,
  input logic         done_o
);
  localparam int unsigned SW = $clog2(W + 2) + 1;

  logic [SW-1:0] since_q;
  logic          seen_q, hold_q;
  logic [W-1:0]  cap_a_q, cap_b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_q <= '0;
      seen_q  <= 1'b0;
      hold_q  <= 1'b0;
      cap_a_q <= '0;
      cap_b_q <= '0;
    end else if (start_i) begin
      since_q <= '0;
      seen_q  <= 1'b1;
      hold_q  <= 1'b0;
      cap_a_q <= a_i;
      cap_b_q <= b_i;
    end else begin
      if (since_q < SW'(W + 1)) since_q <= since_q + 1'b1;
      if (done_o) hold_q <= 1'b1;
    end
  end

  a_r2_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (sum_o == '0 && !carry_o && !done_o));

  a_r3_done_timing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (seen_q && since_q == SW'(W)));

  a_r3_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r4_sum_correct: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ({carry_o, sum_o} == ({1'b0, cap_a_q} + {1'b0, cap_b_q})));

  a_r5_hold_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((done_o || hold_q) && !start_i) |=> ($stable(sum_o) && $stable(carry_o)));
endmodule

bind serial_adder serial_adder_chk #(.W(W)) u_chk (.*);

// File: tb/serial_adder_test.sv
`timescale 1ns/1ps
module serial_adder_test;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic [W-1:0] sum_o;
  logic         carry_o, done_o;

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  logic [W:0] exp_q[$];

  always #4 clk = ~clk;

  serial_adder #(.W(W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i),
    .a_i(a_i), .b_i(b_i), .sum_o(sum_o), .carry_o(carry_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // driver: pushes expected value, pulses start, scrambles inputs (R7)
  task automatic add(input logic [W-1:0] a, input logic [W-1:0] b, input int gap);
    @(negedge clk);
    exp_q.push_back({1'b0, a} + {1'b0, b});
    a_i = a; b_i = b; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; a_i = ~a; b_i = ~b;
    repeat (gap) @(negedge clk);
  endtask

  // monitor / scoreboard
  initial begin : monitor
    int since = 99;
    logic [W:0] cur = '0;
    bit have = 1'b0;
    @(posedge rst_ni);
    forever begin
      @(posedge clk); #2;
      if (start_i) begin
        if (exp_q.size() > 0) cur = exp_q.pop_front();
        since = 0; have = 1'b0;
        chk(sum_o == '0 && !carry_o && !done_o, "R2", {done_o, carry_o, sum_o}, 0);
      end else begin
        if (since < 99) since++;
        if (since == W) begin
          chk(done_o == 1'b1, "R3", done_o, 1);
          chk({carry_o, sum_o} == cur, "R4/R6/R7", {carry_o, sum_o}, cur);
          have = 1'b1;
        end else begin
          chk(done_o == 1'b0, "R3", done_o, 0);
          if (have) chk({carry_o, sum_o} == cur, "R5", {carry_o, sum_o}, cur);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      fails++; checks++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    #3;
    chk(sum_o == '0 && !carry_o && !done_o, "R1", {done_o, carry_o, sum_o}, 0);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk(sum_o == '0 && !carry_o && !done_o, "R1", {done_o, carry_o, sum_o}, 0);
    add(4'h0, 4'h0, W + 2);
    add(4'hF, 4'hF, W + 2);
    add(4'hF, 4'h1, W + 2);
    add(4'h8, 4'h8, W + 2);
    add(4'h5, 4'hA, W + 3);
    add(4'h7, 4'h9, W);
    // R6: restart before done, abandoned pair never reported
    add(4'h3, 4'h4, 1);
    add(4'hC, 4'h6, W + 2);
    add(4'h1, 4'h1, 0);
    add(4'hE, 4'hD, W + 2);
    for (int i = 0; i < 256; i++) add(W'(i >> 4), W'(i), W + (i % 3));
    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule